// File: doc/BRIEF.md
# Multi-Purpose Pin Function Dispatcher

This block turns one general-purpose pin into either a command source or a status reporter, so that device actions can run with no host processor. A configuration word, held outside the block, selects input or output mode. It also supplies a 4-bit input function code, a 4-bit output function code and a per-channel select mask.

In input mode, the pin passes through a two-stage synchronizer and then an edge and pulse detector. The decoder turns the detected events into single-cycle command strobes. Some strobes are global. The others are masked by the channel select. Once after reset, the synchronized pin level is treated as an event and its command is executed. From then on, only edges act.

While the pin owns a function, the matching software trigger input is ignored. Two lock flags gate register writes and NVM writes. In output mode, the pin carries a status bit chosen by the output code.

Top module: `gpio_func_dispatch`

## Requirements
- R1: With both enables clear, the pin produces no strobe and pinOe is low. When the input enable is set, input mode applies and the pin is not driven, even if the output enable is also set.
- R2: Input codes 4'b0010 (fault dump), 4'b0101 (protect) and 4'b0111 (clear) pulse their global strobe on a pin falling edge. A rising edge does nothing for these codes.
- R3: Input codes 4'b0011 (current output) and 4'b0100 (voltage output) pulse the power-down strobe on a fall and the power-up strobe on a rise. Code 4'b1001 pulses wave-stop on a fall and wave-start on a rise. Code 4'b1010 pulses margin-low on a fall and margin-high on a rise. Every one of these carries exactly the bits set in cfgChMask.
- R4: Input code 4'b1000 pulses loadStb on a falling edge, masked by cfgChMask. A rising edge does nothing.
- R5: Input code 4'b1011 pulses resetReqStb on the rising edge that ends a low pulse, but only when the synchronized pin was low for at least MIN_LOW clocks. A shorter pulse, or a rise with no pulse before it, does nothing.
- R6: Both lock flags reset to allowed. Code 4'b1100 allows NVM writes on a fall and blocks them on a rise, as seen at nvmWrOk. Code 4'b1101 does the same for register writes at regWrOk. A write with regWrExempt set passes even when register writes are blocked.
- R7: After reset, once the synchronizer holds valid data, the pin level is acted on once: low acts as a fall and high acts as a rise. After that, only edges act.
- R8: A rising edge on a software trigger (fault dump, protect, clear, reset, per-channel load) pulses the same strobe one clock later. This does not happen while the input code maps the pin to that function.
- R9: In output mode, pinOut follows the selected status bit. Code 4'b0001 selects nvmBusy. Codes 4'b0100 to 4'b0111 select dacBusy[0..3]. Codes 4'b1000 to 4'b1011 select winCmp[0..3]. Any other code drives 0.
- R10: Unused input codes produce no strobe. Every strobe is exactly one clock wide, even when a software trigger is held high.
- R11: A pin change sampled at clock edge k gives its strobe in the cycle after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgInEn | input | 1 | Input mode enable |
| cfgOutEn | input | 1 | Output mode enable |
| cfgInCode | input | 4 | Input function code |
| cfgOutCode | input | 4 | Output status select code |
| cfgChMask | input | NUM_CH | Channel select mask for channel functions |
| pinIn | input | 1 | Raw pin level (asynchronous) |
| pinOut | output | 1 | Pin drive value |
| pinOe | output | 1 | Pin drive enable |
| swFaultDump | input | 1 | Software fault-dump trigger |
| swProtect | input | 1 | Software protect trigger |
| swClear | input | 1 | Software clear trigger |
| swReset | input | 1 | Software reset trigger |
| swLoad | input | NUM_CH | Software per-channel load trigger |
| regWrEn | input | 1 | Register write request |
| regWrExempt | input | 1 | Write targets the unlock or reset field |
| regWrOk | output | 1 | Register write permitted |
| nvmWrEn | input | 1 | NVM write request |
| nvmWrOk | output | 1 | NVM write permitted |
| nvmBusy | input | 1 | NVM busy status |
| dacBusy | input | NUM_CH | Per-channel busy status |
| winCmp | input | NUM_CH | Per-channel window comparator status |
| faultDumpStb | output | 1 | Fault dump strobe |
| protectStb | output | 1 | Protect strobe |
| clearStb | output | 1 | Clear strobe |
| resetReqStb | output | 1 | Device reset request strobe |
| loadStb | output | NUM_CH | Per-channel load strobe |
| ioutDownStb | output | NUM_CH | Current output power-down strobe |
| ioutUpStb | output | NUM_CH | Current output power-up strobe |
| voutDownStb | output | NUM_CH | Voltage output power-down strobe |
| voutUpStb | output | NUM_CH | Voltage output power-up strobe |
| marginLowStb | output | NUM_CH | Margin-low strobe |
| marginHighStb | output | NUM_CH | Margin-high strobe |
| waveStopStb | output | NUM_CH | Waveform stop strobe |
| waveStartStb | output | NUM_CH | Waveform start strobe |

## Verification
A stale previous-level register or a lost boot flag shows up quickly. Within three clocks of a pin change, or of reset release, the bench sees a strobe that should not be there or misses one that should, and reports the whole strobe vector in that exact cycle. A pulse-width counter that counts wrong shows up only at the rise that ends a pulse, so pulses of exactly MIN_LOW and MIN_LOW-1 clocks are driven. A corrupted lock flag stays hidden until the next write request, so regWrOk and nvmWrOk are probed after every lock transition.

// File: rtl/gpio_disp_pkg.sv
package gpio_disp_pkg;

  localparam logic [3:0] IN_FAULT  = 4'b0010;
  localparam logic [3:0] IN_IOUT   = 4'b0011;
  localparam logic [3:0] IN_VOUT   = 4'b0100;
  localparam logic [3:0] IN_PROT   = 4'b0101;
  localparam logic [3:0] IN_CLR    = 4'b0111;
  localparam logic [3:0] IN_LOAD   = 4'b1000;
  localparam logic [3:0] IN_WAVE   = 4'b1001;
  localparam logic [3:0] IN_MARGIN = 4'b1010;
  localparam logic [3:0] IN_RESET  = 4'b1011;
  localparam logic [3:0] IN_NVMLK  = 4'b1100;
  localparam logic [3:0] IN_REGLK  = 4'b1101;

  localparam int OUT_NVM       = 1;
  localparam int OUT_BUSY_BASE = 4;
  localparam int OUT_WIN_BASE  = 8;

  // Events handed from the pin control to the decode datapath
  typedef struct packed {
    logic fallEv;   // falling edge, or low level at boot
    logic riseEv;   // rising edge, or high level at boot
    logic pulseOk;  // low phase lasted at least the minimum length
  } pinEv_t;

endpackage

// File: rtl/gpio_disp_ctrl.sv
module gpio_disp_ctrl
  import gpio_disp_pkg::*;
#(
  parameter int MIN_LOW = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pinIn,
  output pinEv_t ev
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic syncA, syncPin, prevPin;
  logic vld1, vld2, bootDone;
  logic [CW-1:0] lowCnt;
  logic bootEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncPin  <= 1'b1;
      prevPin  <= 1'b1;
      vld1     <= 1'b0;
      vld2     <= 1'b0;
      bootDone <= 1'b0;
      lowCnt   <= '0;
    end else begin
      syncA   <= pinIn;
      syncPin <= syncA;
      vld1    <= 1'b1;
      vld2    <= vld1;
      if (vld2) begin
        bootDone <= 1'b1;
        prevPin  <= syncPin;
        if (syncPin)
          lowCnt <= '0;
        else if (lowCnt != CW'(MIN_LOW))
          lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  always_comb begin
    bootEv     = vld2 && !bootDone;
    ev.fallEv  = bootEv ? !syncPin : (bootDone && prevPin && !syncPin);
    ev.riseEv  = bootEv ?  syncPin : (bootDone && !prevPin && syncPin);
    ev.pulseOk = (lowCnt == CW'(MIN_LOW));
  end

  // R7: a single event per cycle, boot or edge
  assert_edge_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ev.fallEv && ev.riseEv));

  // R7: the boot action appears exactly once, right after the sync stages fill
  assert_boot_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootDone) |-> $past(vld2));

endmodule

// File: rtl/gpio_disp_path.sv
module gpio_disp_path
  import gpio_disp_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgInEn,
  input  logic              cfgOutEn,
  input  logic [3:0]        cfgInCode,
  input  logic [3:0]        cfgOutCode,
  input  logic [NUM_CH-1:0] cfgChMask,
  input  pinEv_t            ev,
  output logic              pinOut,
  output logic              pinOe,
  input  logic              swFaultDump,
  input  logic              swProtect,
  input  logic              swClear,
  input  logic              swReset,
  input  logic [NUM_CH-1:0] swLoad,
  input  logic              regWrEn,
  input  logic              regWrExempt,
  output logic              regWrOk,
  input  logic              nvmWrEn,
  output logic              nvmWrOk,
  input  logic              nvmBusy,
  input  logic [NUM_CH-1:0] dacBusy,
  input  logic [NUM_CH-1:0] winCmp,
  output logic              faultDumpStb,
  output logic              protectStb,
  output logic              clearStb,
  output logic              resetReqStb,
  output logic [NUM_CH-1:0] loadStb,
  output logic [NUM_CH-1:0] ioutDownStb,
  output logic [NUM_CH-1:0] ioutUpStb,
  output logic [NUM_CH-1:0] voutDownStb,
  output logic [NUM_CH-1:0] voutUpStb,
  output logic [NUM_CH-1:0] marginLowStb,
  output logic [NUM_CH-1:0] marginHighStb,
  output logic [NUM_CH-1:0] waveStopStb,
  output logic [NUM_CH-1:0] waveStartStb
);
  localparam int NCODE = 16;

  logic [NCODE-1:0] selOh;
  logic [NUM_CH-1:0] chFall, chRise;
  logic swFaultQ, swProtQ, swClrQ, swRstQ;
  logic [NUM_CH-1:0] swLoadQ;
  logic swFaultRise, swProtRise, swClrRise, swRstRise;
  logic [NUM_CH-1:0] swLoadRise;
  logic nvmLocked, regLocked;
  logic [NCODE-1:0] statVec;
  logic outAct;

  always_comb begin
    selOh       = cfgInEn ? (NCODE'(1) << cfgInCode) : '0;
    chFall      = {NUM_CH{ev.fallEv}} & cfgChMask;
    chRise      = {NUM_CH{ev.riseEv}} & cfgChMask;
    swFaultRise = swFaultDump & ~swFaultQ;
    swProtRise  = swProtect & ~swProtQ;
    swClrRise   = swClear & ~swClrQ;
    swRstRise   = swReset & ~swRstQ;
    swLoadRise  = swLoad & ~swLoadQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swFaultQ      <= 1'b0;
      swProtQ       <= 1'b0;
      swClrQ        <= 1'b0;
      swRstQ        <= 1'b0;
      swLoadQ       <= '0;
      faultDumpStb  <= 1'b0;
      protectStb    <= 1'b0;
      clearStb      <= 1'b0;
      resetReqStb   <= 1'b0;
      loadStb       <= '0;
      ioutDownStb   <= '0;
      ioutUpStb     <= '0;
      voutDownStb   <= '0;
      voutUpStb     <= '0;
      marginLowStb  <= '0;
      marginHighStb <= '0;
      waveStopStb   <= '0;
      waveStartStb  <= '0;
      nvmLocked     <= 1'b0;
      regLocked     <= 1'b0;
    end else begin
      swFaultQ <= swFaultDump;
      swProtQ  <= swProtect;
      swClrQ   <= swClear;
      swRstQ   <= swReset;
      swLoadQ  <= swLoad;

      faultDumpStb <= (selOh[IN_FAULT] & ev.fallEv) | (swFaultRise & ~selOh[IN_FAULT]);
      protectStb   <= (selOh[IN_PROT]  & ev.fallEv) | (swProtRise  & ~selOh[IN_PROT]);
      clearStb     <= (selOh[IN_CLR]   & ev.fallEv) | (swClrRise   & ~selOh[IN_CLR]);
      resetReqStb  <= (selOh[IN_RESET] & ev.riseEv & ev.pulseOk)
                    | (swRstRise & ~selOh[IN_RESET]);
      loadStb      <= (selOh[IN_LOAD] ? chFall : '0)
                    | (swLoadRise & ~{NUM_CH{selOh[IN_LOAD]}});

      ioutDownStb   <= selOh[IN_IOUT]   ? chFall : '0;
      ioutUpStb     <= selOh[IN_IOUT]   ? chRise : '0;
      voutDownStb   <= selOh[IN_VOUT]   ? chFall : '0;
      voutUpStb     <= selOh[IN_VOUT]   ? chRise : '0;
      marginLowStb  <= selOh[IN_MARGIN] ? chFall : '0;
      marginHighStb <= selOh[IN_MARGIN] ? chRise : '0;
      waveStopStb   <= selOh[IN_WAVE]   ? chFall : '0;
      waveStartStb  <= selOh[IN_WAVE]   ? chRise : '0;

      if (selOh[IN_NVMLK] && ev.fallEv) nvmLocked <= 1'b0;
      else if (selOh[IN_NVMLK] && ev.riseEv) nvmLocked <= 1'b1;
      if (selOh[IN_REGLK] && ev.fallEv) regLocked <= 1'b0;
      else if (selOh[IN_REGLK] && ev.riseEv) regLocked <= 1'b1;
    end
  end

  // Output-mode status selection
  always_comb begin
    statVec = '0;
    statVec[OUT_NVM] = nvmBusy;
    for (int ch = 0; ch < NUM_CH && ch < 4; ch++) begin
      statVec[OUT_BUSY_BASE + ch] = dacBusy[ch];
      statVec[OUT_WIN_BASE + ch]  = winCmp[ch];
    end
    outAct  = cfgOutEn & ~cfgInEn;
    pinOe   = outAct;
    pinOut  = outAct & statVec[cfgOutCode];
    regWrOk = regWrEn & (~regLocked | regWrExempt);
    nvmWrOk = nvmWrEn & ~nvmLocked;
  end

  // R1: an unmapped pin produces no channel strobes
  assert_unmapped_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgInEn) |-> (ioutDownStb == '0 && voutUpStb == '0 && marginLowStb == '0
                         && waveStartStb == '0));

  // R5: a reset request needs a pin rise or a software trigger edge behind it
  assert_reset_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    resetReqStb |-> $past(ev.riseEv || swReset));

  // R6: the register lock only engages from the pin mapped to it
  assert_lock_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regLocked) |-> $past(cfgInEn && cfgInCode == IN_REGLK && ev.riseEv));

  // R8: a mapped function ignores its software trigger
  assert_sw_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selOh[IN_FAULT]) && !$past(ev.fallEv)) |-> !faultDumpStb);

  // R10: strobes last one clock
  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (faultDumpStb || resetReqStb) |=> !(faultDumpStb || resetReqStb));

endmodule

// File: rtl/gpio_func_dispatch.sv
module gpio_func_dispatch
  import gpio_disp_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int MIN_LOW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgInEn,
  input  logic              cfgOutEn,
  input  logic [3:0]        cfgInCode,
  input  logic [3:0]        cfgOutCode,
  input  logic [NUM_CH-1:0] cfgChMask,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinOe,
  input  logic              swFaultDump,
  input  logic              swProtect,
  input  logic              swClear,
  input  logic              swReset,
  input  logic [NUM_CH-1:0] swLoad,
  input  logic              regWrEn,
  input  logic              regWrExempt,
  output logic              regWrOk,
  input  logic              nvmWrEn,
  output logic              nvmWrOk,
  input  logic              nvmBusy,
  input  logic [NUM_CH-1:0] dacBusy,
  input  logic [NUM_CH-1:0] winCmp,
  output logic              faultDumpStb,
  output logic              protectStb,
  output logic              clearStb,
  output logic              resetReqStb,
  output logic [NUM_CH-1:0] loadStb,
  output logic [NUM_CH-1:0] ioutDownStb,
  output logic [NUM_CH-1:0] ioutUpStb,
  output logic [NUM_CH-1:0] voutDownStb,
  output logic [NUM_CH-1:0] voutUpStb,
  output logic [NUM_CH-1:0] marginLowStb,
  output logic [NUM_CH-1:0] marginHighStb,
  output logic [NUM_CH-1:0] waveStopStb,
  output logic [NUM_CH-1:0] waveStartStb
);
  pinEv_t ev;

  gpio_disp_ctrl #(.MIN_LOW(MIN_LOW)) ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .ev(ev)
  );

  gpio_disp_path #(.NUM_CH(NUM_CH)) path (
    .clk(clk), .rstN(rstN),
    .cfgInEn(cfgInEn), .cfgOutEn(cfgOutEn), .cfgInCode(cfgInCode),
    .cfgOutCode(cfgOutCode), .cfgChMask(cfgChMask), .ev(ev),
    .pinOut(pinOut), .pinOe(pinOe),
    .swFaultDump(swFaultDump), .swProtect(swProtect), .swClear(swClear),
    .swReset(swReset), .swLoad(swLoad),
    .regWrEn(regWrEn), .regWrExempt(regWrExempt), .regWrOk(regWrOk),
    .nvmWrEn(nvmWrEn), .nvmWrOk(nvmWrOk),
    .nvmBusy(nvmBusy), .dacBusy(dacBusy), .winCmp(winCmp),
    .faultDumpStb(faultDumpStb), .protectStb(protectStb), .clearStb(clearStb),
    .resetReqStb(resetReqStb), .loadStb(loadStb),
    .ioutDownStb(ioutDownStb), .ioutUpStb(ioutUpStb),
    .voutDownStb(voutDownStb), .voutUpStb(voutUpStb),
    .marginLowStb(marginLowStb), .marginHighStb(marginHighStb),
    .waveStopStb(waveStopStb), .waveStartStb(waveStartStb)
  );

endmodule

// File: tb/gpio_func_dispatch_test.sv
module gpio_func_dispatch_test;
  localparam int NUM_CH  = 4;
  localparam int MIN_LOW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgInEn = 1'b0, cfgOutEn = 1'b0;
  logic [3:0] cfgInCode = 4'b0, cfgOutCode = 4'b0;
  logic [3:0] cfgChMask = 4'b0;
  logic pinIn = 1'b1;
  logic pinOut, pinOe;
  logic swFaultDump = 0, swProtect = 0, swClear = 0, swReset = 0;
  logic [3:0] swLoad = 4'b0;
  logic regWrEn = 0, regWrExempt = 0, regWrOk, nvmWrEn = 0, nvmWrOk;
  logic nvmBusy = 0;
  logic [3:0] dacBusy = 4'b0, winCmp = 4'b0;
  logic faultDumpStb, protectStb, clearStb, resetReqStb;
  logic [3:0] loadStb, ioutDownStb, ioutUpStb, voutDownStb, voutUpStb;
  logic [3:0] marginLowStb, marginHighStb, waveStopStb, waveStartStb;

  gpio_func_dispatch #(.NUM_CH(NUM_CH), .MIN_LOW(MIN_LOW)) uut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [39:0] vec;
    string       tag;
  } item_t;
  item_t sbq[$];

  // Field index: 0 fault,1 protect,2 clear,3 reset, 4 load,5 ioutDn,6 ioutUp,
  // 7 voutDn,8 voutUp,9 marginLo,10 marginHi,11 waveStop,12 waveStart
  function automatic logic [39:0] mk(int idx, logic [3:0] m);
    logic [39:0] v = '0;
    if (idx < 4) v[39 - idx] = m[0];
    else v[(12 - idx) * 4 +: 4] = m;
    return v;
  endfunction

  function automatic logic [39:0] obs();
    return {faultDumpStb, protectStb, clearStb, resetReqStb, loadStb,
            ioutDownStb, ioutUpStb, voutDownStb, voutUpStb,
            marginLowStb, marginHighStb, waveStopStb, waveStartStb};
  endfunction

  task automatic push(int dly, logic [39:0] v, string tag);
    item_t it;
    it.at = cyc + dly; it.vec = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: every cycle compares the strobe vector to the scoreboard
  always @(negedge clk) begin
    logic [39:0] exp;
    string tag;
    exp = '0; tag = "idle cycle (R10)";
    if (sbq.size() > 0 && sbq[0].at < cyc) begin
      errors++; checks++;
      $display("FAIL %s missed at %0d actual=none expected=%h", sbq[0].tag, sbq[0].at, sbq[0].vec);
      void'(sbq.pop_front());
    end
    if (sbq.size() > 0 && sbq[0].at == cyc) begin
      exp = sbq[0].vec; tag = sbq[0].tag;
      void'(sbq.pop_front());
    end
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, obs(), exp);
    end
  end

  task automatic doReset(logic lvl);
    @(negedge clk); rstN = 0; pinIn = lvl;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic setCfg(logic inE, logic outE, logic [3:0] code, logic [3:0] mask);
    @(negedge clk);
    cfgInEn = inE; cfgOutEn = outE; cfgInCode = code; cfgChMask = mask;
    repeat (2) @(negedge clk);
  endtask

  task automatic pinTo(logic lvl, logic [39:0] v, string tag);
    @(negedge clk);
    pinIn = lvl;
    if (v != '0) push(3, v, tag);
    repeat (5) @(negedge clk);
  endtask

  task automatic lowPulse(int len, logic [39:0] v, string tag);
    @(negedge clk); pinIn = 0;
    repeat (len) @(negedge clk);
    pinIn = 1;
    if (v != '0) push(3, v, tag);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: boot low level with current-output code acts as a fall
    cfgInEn = 1; cfgInCode = 4'b0011; cfgChMask = 4'b0101;
    doReset(1'b0);
    push(3, mk(5, 4'b0101), "R7 boot low -> iout down");
    repeat (6) @(negedge clk);
    chk(pinOe, 1'b0, "R1 reset state pinOe");
    regWrEn = 1; nvmWrEn = 1; #1;
    chk(regWrOk, 1'b1, "R6 reset regWrOk allowed");
    chk(nvmWrOk, 1'b1, "R6 reset nvmWrOk allowed");
    // R3 / R11: rise -> power-up
    pinTo(1, mk(6, 4'b0101), "R3 R11 iout up on rise");
    pinTo(0, mk(5, 4'b0101), "R3 iout down on fall");
    pinTo(1, mk(6, 4'b0101), "R3 iout up again");

    // R7: boot high level with voltage code acts as a rise
    cfgInCode = 4'b0100; cfgChMask = 4'b1111;
    doReset(1'b1);
    push(3, mk(8, 4'b1111), "R7 boot high -> vout up");
    repeat (6) @(negedge clk);
    pinTo(0, mk(7, 4'b1111), "R3 vout down");
    pinTo(1, mk(8, 4'b1111), "R3 vout up");

    // R2: global codes
    setCfg(1, 0, 4'b0010, 4'b0000);
    pinTo(0, mk(0, 4'b1), "R2 fault dump on fall");
    pinTo(1, '0, "R2 fault rise ignored");
    setCfg(1, 0, 4'b0101, 4'b0000);
    pinTo(0, mk(1, 4'b1), "R2 protect on fall");
    pinTo(1, '0, "R2 protect rise ignored");
    setCfg(1, 0, 4'b0111, 4'b0000);
    pinTo(0, mk(2, 4'b1), "R2 clear on fall");
    pinTo(1, '0, "R2 clear rise ignored");

    // R4: load
    setCfg(1, 0, 4'b1000, 4'b0011);
    pinTo(0, mk(4, 4'b0011), "R4 load on fall");
    pinTo(1, '0, "R4 load rise ignored");

    // R3: wave and margin
    setCfg(1, 0, 4'b1001, 4'b1000);
    pinTo(0, mk(11, 4'b1000), "R3 wave stop");
    pinTo(1, mk(12, 4'b1000), "R3 wave start");
    setCfg(1, 0, 4'b1010, 4'b0110);
    pinTo(0, mk(9, 4'b0110), "R3 margin low");
    pinTo(1, mk(10, 4'b0110), "R3 margin high");

    // R5: reset pulses
    setCfg(1, 0, 4'b1011, 4'b0000);
    lowPulse(MIN_LOW - 1, '0, "R5 short pulse rejected");
    lowPulse(MIN_LOW, mk(3, 4'b1), "R5 pulse at minimum accepted");
    lowPulse(MIN_LOW + 3, mk(3, 4'b1), "R5 long pulse accepted");

    // R6: locks
    setCfg(1, 0, 4'b1100, 4'b0000);
    pinTo(0, '0, "R6 nvm allow");
    chk(nvmWrOk, 1'b1, "R6 nvm allowed after fall");
    pinTo(1, '0, "R6 nvm block");
    chk(nvmWrOk, 1'b0, "R6 nvm blocked after rise");
    pinTo(0, '0, "R6 nvm allow");
    chk(nvmWrOk, 1'b1, "R6 nvm re-allowed");
    pinTo(1, '0, "R6 level restore");
    setCfg(1, 0, 4'b1101, 4'b0000);
    pinTo(0, '0, "R6 reg allow");
    pinTo(1, '0, "R6 reg block");
    regWrExempt = 0; #1;
    chk(regWrOk, 1'b0, "R6 reg write blocked");
    regWrExempt = 1; #1;
    chk(regWrOk, 1'b1, "R6 exempt write passes");
    regWrExempt = 0;
    pinTo(0, '0, "R6 reg allow");
    chk(regWrOk, 1'b1, "R6 reg re-allowed");
    pinTo(1, '0, "R6 level restore");

    // R10: unused code, R1: unmapped
    setCfg(1, 0, 4'b0110, 4'b1111);
    pinTo(0, '0, "R10 unused code fall");
    pinTo(1, '0, "R10 unused code rise");
    setCfg(0, 0, 4'b0011, 4'b1111);
    pinTo(0, '0, "R1 unmapped fall");
    pinTo(1, '0, "R1 unmapped rise");
    chk(pinOe, 1'b0, "R1 unmapped pinOe");

    // R8: software triggers
    @(negedge clk); swFaultDump = 1; push(1, mk(0, 4'b1), "R8 sw fault unmapped");
    repeat (3) @(negedge clk); swFaultDump = 0;  // held: R10 single strobe
    repeat (3) @(negedge clk);
    @(negedge clk); swLoad = 4'b1010; push(1, mk(4, 4'b1010), "R8 sw load");
    @(negedge clk); swLoad = 4'b0;
    @(negedge clk); swReset = 1; push(1, mk(3, 4'b1), "R8 sw reset");
    @(negedge clk); swReset = 0;
    setCfg(1, 0, 4'b0010, 4'b0000);
    @(negedge clk); swFaultDump = 1;  // mapped: ignored
    @(negedge clk); swFaultDump = 0;
    @(negedge clk); swProtect = 1; push(1, mk(1, 4'b1), "R8 sw protect not mapped");
    @(negedge clk); swProtect = 0;
    @(negedge clk); swClear = 1; push(1, mk(2, 4'b1), "R8 sw clear not mapped");
    @(negedge clk); swClear = 0;
    repeat (3) @(negedge clk);

    // R9: output mode
    setCfg(0, 1, 4'b0000, 4'b0000);
    cfgOutCode = 4'b0001; nvmBusy = 1; #1;
    chk(pinOe, 1'b1, "R9 pinOe in output mode");
    chk(pinOut, 1'b1, "R9 nvm busy high");
    nvmBusy = 0; #1;
    chk(pinOut, 1'b0, "R9 nvm busy low");
    cfgOutCode = 4'b0110; dacBusy = 4'b0100; #1;
    chk(pinOut, 1'b1, "R9 dac busy ch2 high");
    dacBusy = 4'b1011; #1;
    chk(pinOut, 1'b0, "R9 dac busy ch2 low");
    cfgOutCode = 4'b1001; winCmp = 4'b0010; #1;
    chk(pinOut, 1'b1, "R9 window ch1 high");
    cfgOutCode = 4'b0011; nvmBusy = 1; dacBusy = 4'hF; winCmp = 4'hF; #1;
    chk(pinOut, 1'b0, "R9 unused out code drives 0");
    cfgInEn = 1; cfgInCode = 4'b0110; #1;
    chk(pinOe, 1'b0, "R1 input wins over output");

    repeat (6) @(negedge clk);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule